// File: doc/BRIEF.md
# Dual-Speed Page-Close Bank Scheduler

This block schedules cache-block requests for one bank of a row-buffer memory that runs an open-page policy. A last-level cache hands it fetches and writebacks over a valid/ready stream. Each request carries a kind, a row and a column. Requests wait in a small pending queue. Whenever the bank is idle, the scheduler takes one request from that queue. It then works out whether the row already in the row buffer can serve the request, or whether that row must be closed and the needed row opened first.

Closing a row is a write phase, and it runs at one of two speeds. A fast close costs more energy and suits fetches, which stall the processor. A slow close saves energy and suits writebacks, which nobody waits on. The speed is chosen from the kind of the request that missed. If the chosen speed differs from the one used for the previous close, a short voltage-switch interval runs before the close phase begins. Fetches may overtake queued writebacks, which keeps the cost of slow closes away from the critical path. A single configuration pin turns this reordering off.

Back-pressure rules: a request is taken on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is low while the queue holds DEPTH entries. It rises only after an entry has left the queue, and a request leaving the queue does not free a slot within the same edge. The requester holds its request stable until it is taken. Completion is reported by a one-cycle `svc_done` pulse, which cannot be back-pressured.

Top module: `bank_dual_close_sched`

## Requirements
- R1: A request whose row equals the open row is served with only a column phase of T_COL cycles, and it increments `cnt_hit`.
- R2: After reset no row is open. The first request of either kind runs only an open phase (T_OPEN) and then a column phase (T_COL), with no close. Its `svc_done` pulse comes T_OPEN+T_COL cycles after the edge that accepted it, provided the queue was empty and the bank idle.
- R3: A request for a row other than the open row runs a close phase, then an open phase of T_OPEN, then a column phase of T_COL. `svc_done` is high in the last column cycle. The next request is taken one cycle later.
- R4: A row miss caused by a writeback (`req_kind`=1) closes with the slow write of T_SLOW cycles and increments `cnt_slow`. A miss caused by a fetch (`req_kind`=0) closes with the fast write of T_FAST cycles and increments `cnt_fast`.
- R5: `close_slow` shows the selected close speed (1 = slow) and is 0 after reset. When a miss needs the other speed, `close_slow` changes on the edge that takes the request, and T_SW switch cycles run before the close phase.
- R6: With `reorder_en`=1, the oldest queued fetch is served ahead of older writebacks. The exception is an older queued writeback with the same row and column as that fetch; then the oldest queued entry is served. With no fetch queued, the oldest entry is served.
- R7: With `reorder_en`=0, requests are served strictly in arrival order.
- R8: `req_ready` is 0 exactly while DEPTH requests are pending, and no request is accepted then.
- R9: After reset `req_ready`=1, `svc_done`=0, `close_slow`=0 and all three counters are 0.
- R10: The counters saturate at 2^CNT_W-1 and then hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reorder_en | input | 1 | 1 lets fetches overtake writebacks |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Queue can take a request |
| req_kind | input | 1 | 0 fetch, 1 writeback |
| req_row | input | ROW_W | Row of the request |
| req_col | input | COL_W | Column of the request |
| svc_done | output | 1 | Column phase of a request finishes this cycle |
| svc_kind | output | 1 | Kind of the finished request |
| svc_row | output | ROW_W | Row of the finished request |
| svc_col | output | COL_W | Column of the finished request |
| close_slow | output | 1 | Selected close speed, 1 = slow |
| cnt_hit | output | CNT_W | Saturating row-hit count |
| cnt_slow | output | CNT_W | Saturating slow-close count |
| cnt_fast | output | CNT_W | Saturating fast-close count |

## Verification
A wrong open-row record or a wrong speed register shows at the ports within one request. It turns up as a `svc_done` pulse that is early or late by a whole phase length, and as a counter that moves in the wrong bucket on the edge that takes the request. A selection error in the queue appears as the wrong row and column on the next `svc_done`. A slot-count error appears as `req_ready` differing from the occupancy expected on that same cycle. The bench's reference model predicts every one of these signals on every cycle, so a divergence is reported on the cycle where it first appears.

// File: rtl/bank_sched_pkg.sv
package bank_sched_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_VSW   = 3'd1,
    PH_CLOSE = 3'd2,
    PH_OPEN  = 3'd3,
    PH_COL   = 3'd4
  } phase_e;

  localparam int EV_HIT  = 0;
  localparam int EV_SLOW = 1;
  localparam int EV_FAST = 2;
  localparam int EV_NUM  = 3;
endpackage

// File: rtl/bank_req_queue.sv
module bank_req_queue #(
  parameter int DEPTH = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reorder_en,
  input  logic             in_push,
  input  logic             in_kind,
  input  logic [ROW_W-1:0] in_row,
  input  logic [COL_W-1:0] in_col,
  input  logic             take,
  output logic             out_nonempty,
  output logic             out_full,
  output logic             out_kind,
  output logic [ROW_W-1:0] out_row,
  output logic [COL_W-1:0] out_col
);
  typedef struct packed {
    logic             kind;
    logic [ROW_W-1:0] row;
    logic [COL_W-1:0] col;
  } ent_t;

  ent_t          slot [DEPTH];
  ent_t          nxt  [DEPTH];
  logic [CW-1:0] count;
  logic [IW-1:0] sel;
  logic [CW-1:0] wpos;
  logic          found, clash;

  // choose the oldest fetch unless an older writeback hits the same address
  always_comb begin
    sel   = '0;
    found = 1'b0;
    clash = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && (CW'(i) < count) && !slot[i].kind) begin
        found = 1'b1;
        sel   = IW'(i);
        for (int j = 0; j < DEPTH; j++) begin
          if (j < i && slot[j].kind && slot[j].row == slot[i].row &&
              slot[j].col == slot[i].col)
            clash = 1'b1;
        end
      end
    end
    if (!reorder_en || clash) sel = '0;
  end

  always_comb begin
    wpos = count - CW'(take);
    for (int i = 0; i < DEPTH; i++) nxt[i] = slot[i];
    for (int i = 0; i < DEPTH - 1; i++)
      if (take && IW'(i) >= sel) nxt[i] = slot[i+1];
    for (int i = 0; i < DEPTH; i++)
      if (in_push && CW'(i) == wpos) nxt[i] = '{kind: in_kind, row: in_row, col: in_col};
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) slot[i] <= nxt[i];
    if (rst) count <= '0;
    else     count <= count + CW'(in_push) - CW'(take);
  end

  assign out_nonempty = (count != '0);
  assign out_full     = (count == CW'(DEPTH));
  assign out_kind     = slot[sel].kind;
  assign out_row      = slot[sel].row;
  assign out_col      = slot[sel].col;

  a_r8_count_bound: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
  a_r8_full_holds: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH) && !take) |=> count == CW'(DEPTH));
  a_r6_pick_in_range: assert property (@(posedge clk) disable iff (rst)
    take |-> (CW'(sel) < count));
endmodule

// File: rtl/bank_phase_ctrl.sv
module bank_phase_ctrl
  import bank_sched_pkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int T_OPEN = 30,
  parameter int T_COL  = 16,
  parameter int T_FAST = 9,
  parameter int T_SLOW = 166,
  parameter int T_SW   = 2,
  localparam int T_A   = (T_OPEN > T_COL) ? T_OPEN : T_COL,
  localparam int T_B   = (T_FAST > T_SLOW) ? T_FAST : T_SLOW,
  localparam int T_C   = (T_A > T_B) ? T_A : T_B,
  localparam int T_MAX = (T_C > T_SW) ? T_C : T_SW,
  localparam int TW    = $clog2(T_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pick_vld,
  input  logic             pick_kind,
  input  logic [ROW_W-1:0] pick_row,
  input  logic [COL_W-1:0] pick_col,
  output logic             idle,
  output logic             done,
  output logic             done_kind,
  output logic [ROW_W-1:0] done_row,
  output logic [COL_W-1:0] done_col,
  output logic             close_slow,
  output logic [EV_NUM-1:0] ev
);
  phase_e           st;
  logic [TW-1:0]    tmr;
  logic             row_open, vsel, cur_kind;
  logic [ROW_W-1:0] open_row, cur_row;
  logic [COL_W-1:0] cur_col;
  logic             hit, miss;

  assign idle = (st == PH_IDLE);
  assign hit  = pick_vld && row_open && (open_row == pick_row);
  assign miss = pick_vld && row_open && (open_row != pick_row);
  assign ev[EV_HIT]  = hit;
  assign ev[EV_SLOW] = miss && pick_kind;
  assign ev[EV_FAST] = miss && !pick_kind;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= PH_IDLE;
      tmr      <= '0;
      row_open <= 1'b0;
      open_row <= '0;
      vsel     <= 1'b0;
      cur_kind <= 1'b0;
      cur_row  <= '0;
      cur_col  <= '0;
    end else begin
      unique case (st)
        PH_IDLE: if (pick_vld) begin
          cur_kind <= pick_kind;
          cur_row  <= pick_row;
          cur_col  <= pick_col;
          if (hit) begin
            st <= PH_COL;  tmr <= TW'(T_COL - 1);
          end else if (!row_open) begin
            st <= PH_OPEN; tmr <= TW'(T_OPEN - 1);
          end else if (pick_kind != vsel) begin
            st <= PH_VSW;  tmr <= TW'(T_SW - 1);
            vsel <= pick_kind;
          end else begin
            st  <= PH_CLOSE;
            tmr <= pick_kind ? TW'(T_SLOW - 1) : TW'(T_FAST - 1);
          end
        end
        PH_VSW: if (tmr == '0) begin
          st  <= PH_CLOSE;
          tmr <= vsel ? TW'(T_SLOW - 1) : TW'(T_FAST - 1);
        end else tmr <= tmr - 1'b1;
        PH_CLOSE: if (tmr == '0) begin
          st <= PH_OPEN; tmr <= TW'(T_OPEN - 1); row_open <= 1'b0;
        end else tmr <= tmr - 1'b1;
        PH_OPEN: if (tmr == '0) begin
          st <= PH_COL; tmr <= TW'(T_COL - 1);
          row_open <= 1'b1; open_row <= cur_row;
        end else tmr <= tmr - 1'b1;
        PH_COL: if (tmr == '0) st <= PH_IDLE;
                else tmr <= tmr - 1'b1;
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign done       = (st == PH_COL) && (tmr == '0);
  assign done_kind  = cur_kind;
  assign done_row   = cur_row;
  assign done_col   = cur_col;
  assign close_slow = vsel;

  a_r3_close_then_open: assert property (@(posedge clk) disable iff (rst)
    (st == PH_CLOSE && tmr == '0) |=> st == PH_OPEN);
  a_r5_switch_then_close: assert property (@(posedge clk) disable iff (rst)
    (st == PH_VSW && tmr == '0) |=> st == PH_CLOSE);
  a_r4_speed_follows_kind: assert property (@(posedge clk) disable iff (rst)
    (st == PH_CLOSE) |-> close_slow == cur_kind);
  a_r2_close_needs_open_row: assert property (@(posedge clk) disable iff (rst)
    (st == PH_CLOSE) |-> row_open);
  a_r1_hit_goes_to_column: assert property (@(posedge clk) disable iff (rst)
    (idle && hit) |=> st == PH_COL);
endmodule

// File: rtl/bank_stat_cnt.sv
module bank_stat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] value
);
  always_ff @(posedge clk) begin
    if (rst)                     value <= '0;
    else if (inc && value != '1) value <= value + 1'b1;
  end

  a_r10_hold_at_max: assert property (@(posedge clk) disable iff (rst)
    (value == '1) |=> value == '1);
endmodule

// File: rtl/bank_dual_close_sched.sv
module bank_dual_close_sched
  import bank_sched_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int CNT_W  = 16,
  parameter int T_OPEN = 30,
  parameter int T_COL  = 16,
  parameter int T_FAST = 9,
  parameter int T_SLOW = 166,
  parameter int T_SW   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reorder_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_kind,
  input  logic [ROW_W-1:0] req_row,
  input  logic [COL_W-1:0] req_col,
  output logic             svc_done,
  output logic             svc_kind,
  output logic [ROW_W-1:0] svc_row,
  output logic [COL_W-1:0] svc_col,
  output logic             close_slow,
  output logic [CNT_W-1:0] cnt_hit,
  output logic [CNT_W-1:0] cnt_slow,
  output logic [CNT_W-1:0] cnt_fast
);
  logic             q_nonempty, q_full, q_kind, idle, take;
  logic [ROW_W-1:0] q_row;
  logic [COL_W-1:0] q_col;
  logic [EV_NUM-1:0] ev;
  logic [CNT_W-1:0] stat [EV_NUM];

  assign req_ready = !q_full;
  assign take      = idle && q_nonempty;

  bank_req_queue #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_queue (
    .clk(clk), .rst(rst), .reorder_en(reorder_en),
    .in_push(req_valid && req_ready), .in_kind(req_kind),
    .in_row(req_row), .in_col(req_col), .take(take),
    .out_nonempty(q_nonempty), .out_full(q_full),
    .out_kind(q_kind), .out_row(q_row), .out_col(q_col));

  bank_phase_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .T_OPEN(T_OPEN),
    .T_COL(T_COL), .T_FAST(T_FAST), .T_SLOW(T_SLOW), .T_SW(T_SW)) u_ctrl (
    .clk(clk), .rst(rst), .pick_vld(take), .pick_kind(q_kind),
    .pick_row(q_row), .pick_col(q_col), .idle(idle), .done(svc_done),
    .done_kind(svc_kind), .done_row(svc_row), .done_col(svc_col),
    .close_slow(close_slow), .ev(ev));

  for (genvar g = 0; g < EV_NUM; g++) begin : g_stat
    bank_stat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(ev[g]), .value(stat[g]));
  end

  assign cnt_hit  = stat[EV_HIT];
  assign cnt_slow = stat[EV_SLOW];
  assign cnt_fast = stat[EV_FAST];

  a_r8_no_accept_when_full: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && !take) |=> !req_ready);
  a_r4_one_event_per_pick: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ev));
endmodule

// File: tb/bank_dual_close_sched_bench.sv
module bank_dual_close_sched_bench;
  localparam int DEPTH = 4, ROW_W = 8, COL_W = 6, CNT_W = 4;
  localparam int T_OPEN = 30, T_COL = 16, T_FAST = 9, T_SLOW = 166, T_SW = 2;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst = 1'b1, reorder_en = 1'b1;
  logic req_valid = 1'b0, req_kind = 1'b0;
  logic [ROW_W-1:0] req_row = '0;
  logic [COL_W-1:0] req_col = '0;
  logic req_ready, svc_done, svc_kind, close_slow;
  logic [ROW_W-1:0] svc_row;
  logic [COL_W-1:0] svc_col;
  logic [CNT_W-1:0] cnt_hit, cnt_slow, cnt_fast;

  always #2.5 clk = ~clk;

  bank_dual_close_sched #(.DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W),
    .CNT_W(CNT_W), .T_OPEN(T_OPEN), .T_COL(T_COL), .T_FAST(T_FAST),
    .T_SLOW(T_SLOW), .T_SW(T_SW)) u_bank_dual_close_sched (
    .clk(clk), .rst(rst), .reorder_en(reorder_en), .req_valid(req_valid),
    .req_ready(req_ready), .req_kind(req_kind), .req_row(req_row),
    .req_col(req_col), .svc_done(svc_done), .svc_kind(svc_kind),
    .svc_row(svc_row), .svc_col(svc_col), .close_slow(close_slow),
    .cnt_hit(cnt_hit), .cnt_slow(cnt_slow), .cnt_fast(cnt_fast));

  int n_run = 0, n_fail = 0;
  bit saw_full = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  typedef struct { int kind; int row; int col; } mreq_t;
  mreq_t mq[$];
  mreq_t m_cur;
  int m_rem = 0, m_open_row = 0, m_hit = 0, m_slow = 0, m_fast = 0;
  bit m_open = 0, m_vsel = 0, m_done = 0;

  function automatic int model_pick();
    for (int i = 0; i < mq.size(); i++) begin
      if (mq[i].kind == 0) begin
        if (!reorder_en) return 0;
        for (int j = 0; j < i; j++)
          if (mq[j].kind == 1 && mq[j].row == mq[i].row && mq[j].col == mq[i].col)
            return 0;
        return i;
      end
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mq.delete(); m_rem = 0; m_open = 0; m_vsel = 0; m_done = 0;
      m_hit = 0; m_slow = 0; m_fast = 0;
    end else begin
      bit acc;
      acc = req_valid && (mq.size() < DEPTH);
      if (m_rem > 0) m_rem--;
      else if (mq.size() > 0) begin
        int idx, lat;
        idx = model_pick();
        m_cur = mq[idx];
        mq.delete(idx);
        if (m_open && m_open_row == m_cur.row) begin
          lat = T_COL;
          if (m_hit < CMAX) m_hit++;
        end else if (!m_open) begin
          lat = T_OPEN + T_COL;
        end else begin
          lat = ((m_cur.kind == 1) ? T_SLOW : T_FAST) + T_OPEN + T_COL;
          if (m_vsel != (m_cur.kind == 1)) lat += T_SW;
          m_vsel = (m_cur.kind == 1);
          if (m_cur.kind == 1) begin if (m_slow < CMAX) m_slow++; end
          else begin if (m_fast < CMAX) m_fast++; end
        end
        m_open = 1; m_open_row = m_cur.row;
        m_rem = lat;
      end
      if (acc) mq.push_back('{kind: int'(req_kind), row: int'(req_row), col: int'(req_col)});
      m_done = (m_rem == 1);
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(req_ready == (mq.size() < DEPTH), "R8 ready", req_ready, mq.size() < DEPTH);
      if (!req_ready) saw_full = 1;
      chk(svc_done == m_done, "R3 done timing", svc_done, m_done);
      if (m_done && svc_done) begin
        chk(int'(svc_row) == m_cur.row && int'(svc_col) == m_cur.col &&
            int'(svc_kind) == m_cur.kind,
            reorder_en ? "R6 service order" : "R7 arrival order",
            int'(svc_row) * 256 + int'(svc_col), m_cur.row * 256 + m_cur.col);
      end
      chk(close_slow == m_vsel, "R5 close speed", close_slow, m_vsel);
      chk(int'(cnt_hit) == m_hit, "R1 hit count", cnt_hit, m_hit);
      chk(int'(cnt_slow) == m_slow, "R4 slow count", cnt_slow, m_slow);
      chk(int'(cnt_fast) == m_fast, "R4 fast count", cnt_fast, m_fast);
    end
  end

  task automatic push(input bit k, input int r, input int c);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_row = ROW_W'(r); req_col = COL_W'(c);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    while (mq.size() > 0 || m_rem > 0) @(negedge clk);
    @(negedge clk);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_fail++; n_run++;
      $display("FAIL watchdog: actual %0d expected %0d", wd, 150000);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    chk(svc_done == 1'b0, "R9 no done after reset", svc_done, 0);
    chk(close_slow == 1'b0, "R9 fast after reset", close_slow, 0);
    chk(cnt_hit == 0 && cnt_slow == 0 && cnt_fast == 0, "R9 counters zero",
        int'(cnt_hit) + int'(cnt_slow) + int'(cnt_fast), 0);

    // R2 first request opens only
    begin
      int k;
      push(1'b1, 5, 1);
      k = 0;
      do begin @(negedge clk); k++; end while (!svc_done && k < 400);
      chk(k == T_OPEN + T_COL, "R2 first open-only latency", k, T_OPEN + T_COL);
      chk(cnt_slow == 0 && cnt_fast == 0, "R2 no close", int'(cnt_slow) + int'(cnt_fast), 0);
    end
    drain();

    // R1 hit, R4/R5 slow and fast misses with switches
    push(1'b0, 5, 2);
    drain();
    push(1'b1, 7, 0);
    drain();
    push(1'b1, 8, 3);
    drain();
    push(1'b0, 5, 0);
    drain();

    // R6 reordering with an address clash, R8 queue full
    reorder_en = 1'b1;
    push(1'b1, 9, 0);
    push(1'b1, 9, 1);
    push(1'b1, 10, 2);
    push(1'b0, 9, 1);
    push(1'b0, 3, 4);
    push(1'b0, 4, 0);
    drain();
    chk(saw_full, "R8 full seen", saw_full, 1);

    // R7 strict order
    reorder_en = 1'b0;
    push(1'b1, 11, 0);
    push(1'b1, 12, 1);
    push(1'b0, 13, 2);
    push(1'b0, 11, 3);
    push(1'b1, 13, 2);
    drain();

    // R10 hit counter saturation
    reorder_en = 1'b1;
    for (int i = 0; i < CMAX + 4; i++) push(1'b0, 13, i % 8);
    drain();
    chk(int'(cnt_hit) == CMAX, "R10 hit saturates", cnt_hit, CMAX);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule